// File: doc/BRIEF.md
# Three-wire serial EEPROM word reader

This block reads 16-bit words out of a three-wire serial EEPROM. The host presents a word address with a one-cycle start strobe. The block then raises the device select line and clocks out a read opcode followed by the address. It clocks in sixteen data bits and closes the access with a fixed sequence: select and data-in low, then one extra full clock pulse. After that it returns the word together with a one-cycle done pulse.

Every serial-clock phase and every data-in setup interval has a minimum length given in nanoseconds. The block turns each of these into a count of system clocks from the system clock frequency, rounding up. The defaults give microsecond-scale phases.

A built-in sequencer reuses the same engine to read every word of the device in ascending address order. It forms their 16-bit wrapping sum and reports whether that sum equals a fixed board identifier. This supports a power-up integrity check.

Top module: `eeprd_top`

## Requirements
- R1: `ee_cs` is low out of reset and whenever `busy` is low. After an accepted start, `ee_cs` rises with `ee_di` and `ee_sk` low. It stays high without a break through the opcode, address and data phases.
- R2: The command shifted out is the read opcode (default 3 bits, value 3'b110) followed by the `ADDR_W`-bit word address, both most-significant bit first, one bit per rising `ee_sk`. `ee_di` only changes while `ee_sk` is low. Each rising `ee_sk` comes at least SETUP cycles after the last change of `ee_di`, where SETUP = ceil(SETUP_NS·CLK_MHZ/1000).
- R3: Every high and every low level of `ee_sk` lasts at least PHASE = ceil(PHASE_NS·CLK_MHZ/1000) system clocks. Low levels last at least max(PHASE, SETUP).
- R4: After the last command bit, `ee_di` is held low for the rest of the access.
- R5: Exactly sixteen data bits are taken from `ee_do` during the high phase of each data clock, most-significant first. The completed word appears on `rd_data` in the cycle `rd_done` is high.
- R6: After the sixteenth data bit, `ee_cs` and `ee_di` go low, and exactly one complete `ee_sk` pulse is issued with `ee_cs` low before `rd_done`.
- R7: `rd_done` is a single-cycle pulse. `busy` is high from the cycle after an accepted start until the read finishes, and is low in the cycle `rd_done` is high.
- R8: A `rd_start` or `sum_start` pulse while `busy` is high is ignored. The read in progress returns its own word, and no extra device access or done pulse follows.
- R9: A `sum_start` pulse reads addresses 0 to 2^ADDR_W−1 in ascending order and sums the words modulo 2^16. It then pulses `sum_done` for one cycle, with `sum_value` holding the sum and `sum_ok` high exactly when the sum equals `BOARD_ID`. `rd_done` does not pulse during the sequence.
- R10: When `rd_start` and `sum_start` arrive together while idle, the single read is performed and the sequence is not started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_start | input | 1 | Start a single-word read |
| rd_addr | input | ADDR_W | Word address for a single read |
| sum_start | input | 1 | Start the whole-device sum sequence |
| busy | output | 1 | An access or sequence is in progress |
| rd_done | output | 1 | One-cycle pulse, single read finished |
| rd_data | output | 16 | Word returned by the last read |
| sum_done | output | 1 | One-cycle pulse, sum sequence finished |
| sum_ok | output | 1 | Sum equals the board identifier |
| sum_value | output | 16 | 16-bit sum of all words |
| ee_cs | output | 1 | Device select |
| ee_sk | output | 1 | Serial clock to the device |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data from the device |

## Verification
`busy` is due one cycle after the start edge and is checked at the following falling edge. The single-read result comes at the end of the close-out, about 2·PHASE·(command bits + 17) cycles later. The bench does not predict that cycle count. It polls `rd_done` at falling edges within a bounded window, and `sum_done` is awaited the same way. The pin timing of R2 and R3 is measured in the EEPROM model from the times of the `ee_sk` and `ee_di` edges. It is compared against the cycle counts recomputed in the bench from the nanosecond parameters.

// File: rtl/eeprd_pkg.sv
package eeprd_pkg;

    localparam int WORD_W = 16;

    // Cycles needed to cover t_ns at clk_mhz, rounded up, never below one.
    function automatic int ns_to_cycles(input int t_ns, input int clk_mhz);
        int c;
        c = (t_ns * clk_mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    typedef enum logic [3:0] {
        E_IDLE,
        E_SEL,
        E_CMD_LO,
        E_CMD_HI,
        E_DAT_LO,
        E_DAT_HI,
        E_END_LO,
        E_TRL_HI,
        E_TRL_LO
    } eng_state_e;

    typedef enum logic [1:0] {
        Q_IDLE,
        Q_ISSUE,
        Q_WAIT
    } seq_state_e;

endpackage

// File: rtl/eeprd_timer.sv
module eeprd_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [TW-1:0] len,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= len - TW'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - TW'(1);
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/eeprd_engine.sv
module eeprd_engine
    import eeprd_pkg::*;
#(
    parameter int              OP_W   = 3,
    parameter logic [OP_W-1:0] RD_OP  = 3'b110,
    parameter int              ADDR_W = 6,
    parameter int              HI_CYC = 8,
    parameter int              LO_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] data,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int CMD_W = OP_W + ADDR_W;
    localparam int MAXB  = imax(CMD_W, WORD_W);
    localparam int CW    = $clog2(MAXB);
    localparam int TW    = $clog2(imax(HI_CYC, LO_CYC) + 1);

    eng_state_e        st, st_n;
    logic [CMD_W-1:0]  cmd_sr;
    logic [CW-1:0]     bit_cnt;
    logic [WORD_W-1:0] in_sr;
    logic              do_m, do_s;
    logic              tmr_go, tmr_zero;
    logic [TW-1:0]     tmr_len;
    logic              last_cmd, last_dat;

    eeprd_timer #(.TW(TW)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .restart (tmr_go),
        .len     (tmr_len),
        .zero    (tmr_zero)
    );

    assign last_cmd = (bit_cnt == CW'(CMD_W - 1));
    assign last_dat = (bit_cnt == CW'(WORD_W - 1));

    always_comb begin
        st_n    = st;
        tmr_go  = 1'b0;
        tmr_len = TW'(LO_CYC);
        if (st == E_IDLE) begin
            if (start) begin
                st_n   = E_SEL;
                tmr_go = 1'b1;
            end
        end else if (tmr_zero) begin
            tmr_go = 1'b1;
            case (st)
                E_SEL:    st_n = E_CMD_LO;
                E_CMD_LO: begin st_n = E_CMD_HI; tmr_len = TW'(HI_CYC); end
                E_CMD_HI: st_n = last_cmd ? E_DAT_LO : E_CMD_LO;
                E_DAT_LO: begin st_n = E_DAT_HI; tmr_len = TW'(HI_CYC); end
                E_DAT_HI: st_n = last_dat ? E_END_LO : E_DAT_LO;
                E_END_LO: begin st_n = E_TRL_HI; tmr_len = TW'(HI_CYC); end
                E_TRL_HI: st_n = E_TRL_LO;
                E_TRL_LO: begin st_n = E_IDLE; tmr_go = 1'b0; end
                default:  st_n = E_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= E_IDLE;
            cmd_sr  <= '0;
            bit_cnt <= '0;
            in_sr   <= '0;
            data    <= '0;
            done    <= 1'b0;
            do_m    <= 1'b0;
            do_s    <= 1'b0;
        end else begin
            st   <= st_n;
            done <= 1'b0;
            do_m <= ee_do;
            do_s <= do_m;
            if (st == E_IDLE && start) begin
                cmd_sr  <= {RD_OP, addr};
                bit_cnt <= '0;
            end
            if (tmr_zero) begin
                case (st)
                    E_CMD_HI: begin
                        if (last_cmd) begin
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + CW'(1);
                            cmd_sr  <= {cmd_sr[CMD_W-2:0], 1'b0};
                        end
                    end
                    E_DAT_HI: begin
                        in_sr <= {in_sr[WORD_W-2:0], do_s};
                        if (!last_dat) bit_cnt <= bit_cnt + CW'(1);
                    end
                    E_TRL_LO: begin
                        done <= 1'b1;
                        data <= in_sr;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign busy  = (st != E_IDLE);
    assign ee_cs = (st == E_SEL) || (st == E_CMD_LO) || (st == E_CMD_HI) ||
                   (st == E_DAT_LO) || (st == E_DAT_HI);
    assign ee_sk = (st == E_CMD_HI) || (st == E_DAT_HI) || (st == E_TRL_HI);
    assign ee_di = ((st == E_CMD_LO) || (st == E_CMD_HI)) && cmd_sr[CMD_W-1];
endmodule

// File: rtl/eeprd_sumseq.sv
module eeprd_sumseq
    import eeprd_pkg::*;
#(
    parameter int              ADDR_W   = 6,
    parameter logic [WORD_W-1:0] BOARD_ID = 16'h0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              eng_done,
    input  logic [WORD_W-1:0] eng_data,
    output logic              eng_start,
    output logic [ADDR_W-1:0] eng_addr,
    output logic              active,
    output logic              sum_done,
    output logic              sum_ok,
    output logic [WORD_W-1:0] sum_value
);
    seq_state_e        st;
    logic [WORD_W-1:0] acc, acc_n;

    assign acc_n = acc + eng_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= Q_IDLE;
            acc       <= '0;
            eng_addr  <= '0;
            sum_done  <= 1'b0;
            sum_ok    <= 1'b0;
            sum_value <= '0;
        end else begin
            sum_done <= 1'b0;
            case (st)
                Q_IDLE: if (go) begin
                    st       <= Q_ISSUE;
                    acc      <= '0;
                    eng_addr <= '0;
                end
                Q_ISSUE: st <= Q_WAIT;
                Q_WAIT: if (eng_done) begin
                    acc <= acc_n;
                    if (&eng_addr) begin
                        st        <= Q_IDLE;
                        sum_done  <= 1'b1;
                        sum_value <= acc_n;
                        sum_ok    <= (acc_n == BOARD_ID);
                    end else begin
                        eng_addr <= eng_addr + ADDR_W'(1);
                        st       <= Q_ISSUE;
                    end
                end
                default: st <= Q_IDLE;
            endcase
        end
    end

    assign eng_start = (st == Q_ISSUE);
    assign active    = (st != Q_IDLE);
endmodule

// File: rtl/eeprd_top.sv
module eeprd_top
    import eeprd_pkg::*;
#(
    parameter int                CLK_MHZ  = 125,
    parameter int                PHASE_NS = 8380,
    parameter int                SETUP_NS = 400,
    parameter int                OP_W     = 3,
    parameter logic [OP_W-1:0]   RD_OP    = 3'b110,
    parameter int                ADDR_W   = 6,
    parameter logic [WORD_W-1:0] BOARD_ID = 16'h0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_start,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              sum_start,
    output logic              busy,
    output logic              rd_done,
    output logic [WORD_W-1:0] rd_data,
    output logic              sum_done,
    output logic              sum_ok,
    output logic [WORD_W-1:0] sum_value,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int PHASE_CYC = ns_to_cycles(PHASE_NS, CLK_MHZ);
    localparam int SETUP_CYC = ns_to_cycles(SETUP_NS, CLK_MHZ);
    localparam int LOW_CYC   = imax(PHASE_CYC, SETUP_CYC);

    logic              eng_busy, eng_done, eng_start;
    logic [ADDR_W-1:0] eng_addr, seq_addr;
    logic              seq_start, seq_active;
    logic              take_rd, take_sum;

    assign busy     = eng_busy | seq_active;
    assign take_rd  = rd_start & ~busy;
    assign take_sum = sum_start & ~busy & ~rd_start;

    assign eng_start = seq_active ? seq_start : take_rd;
    assign eng_addr  = seq_active ? seq_addr : rd_addr;
    assign rd_done   = eng_done & ~seq_active;

    eeprd_engine #(
        .OP_W   (OP_W),
        .RD_OP  (RD_OP),
        .ADDR_W (ADDR_W),
        .HI_CYC (PHASE_CYC),
        .LO_CYC (LOW_CYC)
    ) u_eng (
        .clk   (clk),
        .rst   (rst),
        .start (eng_start),
        .addr  (eng_addr),
        .busy  (eng_busy),
        .done  (eng_done),
        .data  (rd_data),
        .ee_cs (ee_cs),
        .ee_sk (ee_sk),
        .ee_di (ee_di),
        .ee_do (ee_do)
    );

    eeprd_sumseq #(
        .ADDR_W   (ADDR_W),
        .BOARD_ID (BOARD_ID)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (take_sum),
        .eng_done  (eng_done),
        .eng_data  (rd_data),
        .eng_start (seq_start),
        .eng_addr  (seq_addr),
        .active    (seq_active),
        .sum_done  (sum_done),
        .sum_ok    (sum_ok),
        .sum_value (sum_value)
    );
endmodule

// File: rtl/eeprd_chk.sv
module eeprd_chk #(
    parameter int MIN_RUN = 4
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic rd_done,
    input logic sum_done,
    input logic ee_cs,
    input logic ee_sk,
    input logic ee_di
);
    logic        sk_d;
    logic [15:0] run;

    // Length of the current serial-clock level in system clocks.
    always_ff @(posedge clk) begin
        if (rst) begin
            sk_d <= 1'b0;
            run  <= '1;
        end else begin
            sk_d <= ee_sk;
            if (ee_sk != sk_d) run <= 16'd1;
            else if (run != '1) run <= run + 16'd1;
        end
    end

    a_r3_min_phase: assert property (@(posedge clk) disable iff (rst)
        (ee_sk != sk_d) |-> (run >= 16'(MIN_RUN)));

    a_r2_di_still_when_high: assert property (@(posedge clk) disable iff (rst)
        ee_sk |-> $stable(ee_di));

    a_r6_cs_drop_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(ee_cs) |-> (!ee_sk && !ee_di));

    a_r1_cs_only_busy: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ee_cs);

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> !rd_done);

    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> !busy);

    a_r9_sum_single: assert property (@(posedge clk) disable iff (rst)
        sum_done |=> !sum_done);
endmodule

bind eeprd_top eeprd_chk #(.MIN_RUN(PHASE_CYC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .rd_done  (rd_done),
    .sum_done (sum_done),
    .ee_cs    (ee_cs),
    .ee_sk    (ee_sk),
    .ee_di    (ee_di)
);

// File: tb/eeprd_top_tb.sv
`timescale 1ns/1ps
module eeprd_top_tb;
    localparam int CLK_MHZ  = 125;
    localparam int PHASE_NS = 40;
    localparam int SETUP_NS = 16;
    localparam int PHASE_C  = (PHASE_NS * CLK_MHZ + 999) / 1000;
    localparam int SETUP_C  = (SETUP_NS * CLK_MHZ + 999) / 1000;
    localparam logic [15:0] ID = 16'h5A3C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_start = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic        sum_start = 1'b0;
    logic        busy, rd_done, sum_done, sum_ok;
    logic [15:0] rd_data, sum_value;
    logic        ee_cs, ee_sk, ee_di;
    logic        ee_do = 1'b0;

    always #4 clk = ~clk;

    eeprd_top #(
        .CLK_MHZ (CLK_MHZ), .PHASE_NS (PHASE_NS), .SETUP_NS (SETUP_NS),
        .BOARD_ID (ID)
    ) u_dut (
        .clk (clk), .rst (rst), .rd_start (rd_start), .rd_addr (rd_addr),
        .sum_start (sum_start), .busy (busy), .rd_done (rd_done),
        .rd_data (rd_data), .sum_done (sum_done), .sum_ok (sum_ok),
        .sum_value (sum_value), .ee_cs (ee_cs), .ee_sk (ee_sk),
        .ee_di (ee_di), .ee_do (ee_do)
    );

    int total = 0;
    int bad   = 0;

    // EEPROM model and pin-timing monitor
    logic [15:0] mem [64];
    logic [8:0]  cmd;
    logic [5:0]  last_addr;
    logic [6:0]  seq_next;
    bit          seq_mode = 1'b0;
    bit          in_data;
    int bit_n, dcnt;
    int cs_rises = 0, trl_cnt = 0;
    int setup_err = 0, op_err = 0, phase_err = 0, di_err = 0, seq_err = 0;
    int rd_done_cnt = 0, sum_done_cnt = 0;
    time di_t = 0, sk_t = 0;

    always @(ee_di) di_t = $time;

    always @(ee_sk) begin
        if (($time - sk_t) < PHASE_C * 8) phase_err++;
        sk_t = $time;
    end

    always @(posedge ee_cs) begin
        bit_n = 0; cmd = '0; in_data = 1'b0; trl_cnt = 0; cs_rises++;
    end

    always @(posedge ee_sk) begin
        if (!ee_cs) begin
            trl_cnt++;
        end else if (!in_data) begin
            if (($time - di_t) < SETUP_C * 8) setup_err++;
            cmd = {cmd[7:0], ee_di};
            bit_n++;
            if (bit_n == 9) begin
                if (cmd[8:6] != 3'b110) op_err++;
                last_addr = cmd[5:0];
                in_data = 1'b1;
                dcnt = 0;
                if (seq_mode) begin
                    if ({1'b0, cmd[5:0]} != seq_next) seq_err++;
                    seq_next = seq_next + 7'd1;
                end
            end
        end else begin
            if (ee_di) di_err++;
            if (dcnt < 16) ee_do <= mem[last_addr][15 - dcnt];
            dcnt++;
        end
    end

    always @(negedge clk) begin
        if (rd_done) rd_done_cnt++;
        if (sum_done) sum_done_cnt++;
    end

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mem_sum();
        logic [15:0] s = '0;
        for (int i = 0; i < 64; i++) s = s + mem[i];
        return s;
    endfunction

    task automatic wait_rd_done();
        int n = 0;
        while (!rd_done && n < 4000) begin @(negedge clk); n++; end
    endtask

    task automatic do_read(input logic [5:0] a);
        int rises0;
        setup_err = 0; op_err = 0; phase_err = 0; di_err = 0;
        rises0 = cs_rises;
        @(negedge clk);
        rd_addr = a; rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        chk(busy == 1'b1, "R7 busy after start", 32'(busy), 1);
        wait_rd_done();
        chk(rd_done == 1'b1, "R7 done seen", 32'(rd_done), 1);
        chk(busy == 1'b0, "R7 busy low at done", 32'(busy), 0);
        chk(rd_data == mem[a], "R5 data word", 32'(rd_data), 32'(mem[a]));
        chk(last_addr == a, "R2 address sent", 32'(last_addr), 32'(a));
        chk(op_err == 0 && setup_err == 0, "R2 opcode and setup",
            32'(op_err + setup_err), 0);
        chk(phase_err == 0, "R3 clock phase length", 32'(phase_err), 0);
        chk(di_err == 0, "R4 di low in data phase", 32'(di_err), 0);
        chk(trl_cnt == 1, "R6 trailing clock pulses", 32'(trl_cnt), 1);
        chk(cs_rises == rises0 + 1, "R1 one select per read",
            32'(cs_rises - rises0), 1);
        @(negedge clk);
        chk(rd_done == 1'b0, "R7 done one cycle", 32'(rd_done), 0);
    endtask

    task automatic run_sum(input bit exp_ok);
        int n = 0;
        int rd0;
        logic [15:0] es;
        es = mem_sum();
        seq_mode = 1'b1; seq_next = '0; seq_err = 0;
        rd0 = rd_done_cnt;
        @(negedge clk);
        sum_start = 1'b1;
        @(negedge clk);
        sum_start = 1'b0;
        while (!sum_done && n < 40000) begin @(negedge clk); n++; end
        chk(sum_done == 1'b1, "R9 sum done seen", 32'(sum_done), 1);
        chk(sum_value == es, "R9 sum value", 32'(sum_value), 32'(es));
        chk(sum_ok == exp_ok, "R9 sum match flag", 32'(sum_ok), 32'(exp_ok));
        chk(seq_next == 7'd64 && seq_err == 0, "R9 ascending addresses",
            32'(seq_next), 64);
        chk(rd_done_cnt == rd0, "R9 no read done during sum",
            32'(rd_done_cnt - rd0), 0);
        seq_mode = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_all();
        logic [15:0] part;
        int rises0, sums0;
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
        mem[5] = 16'h0000; mem[6] = 16'hFFFF; mem[7] = 16'hAAAA;
        mem[63] = 16'h0000;
        part = mem_sum();
        mem[63] = ID - part;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ee_cs == 0 && ee_sk == 0 && ee_di == 0, "R1 pins idle after reset",
            {29'd0, ee_cs, ee_sk, ee_di}, 0);
        chk(busy == 0 && rd_done == 0 && sum_done == 0, "R7 flags idle after reset",
            {29'd0, busy, rd_done, sum_done}, 0);

        // Directed corners: address ends, all-zero, all-one, alternating words
        do_read(6'd0);
        do_read(6'd63);
        do_read(6'd5);
        do_read(6'd6);
        do_read(6'd7);
        for (int i = 0; i < 8; i++) do_read(6'($urandom_range(63, 0)));

        // R8: starts while busy are ignored
        rises0 = cs_rises; sums0 = sum_done_cnt;
        @(negedge clk); rd_addr = 6'd20; rd_start = 1'b1;
        @(negedge clk); rd_start = 1'b0;
        repeat (30) @(negedge clk);
        rd_addr = 6'd21; rd_start = 1'b1; sum_start = 1'b1;
        @(negedge clk); rd_start = 1'b0; sum_start = 1'b0; rd_addr = 6'd20;
        wait_rd_done();
        chk(rd_data == mem[20], "R8 busy start keeps word", 32'(rd_data),
            32'(mem[20]));
        repeat (60) @(negedge clk);
        chk(cs_rises == rises0 + 1, "R8 no extra access", 32'(cs_rises - rises0), 1);
        chk(sum_done_cnt == sums0 && !busy, "R8 no sequence started",
            32'(sum_done_cnt - sums0), 0);

        // R10: simultaneous starts, the single read wins
        rises0 = cs_rises; sums0 = sum_done_cnt;
        @(negedge clk); rd_addr = 6'd33; rd_start = 1'b1; sum_start = 1'b1;
        @(negedge clk); rd_start = 1'b0; sum_start = 1'b0;
        wait_rd_done();
        chk(rd_data == mem[33], "R10 read taken", 32'(rd_data), 32'(mem[33]));
        repeat (60) @(negedge clk);
        chk(cs_rises == rises0 + 1 && !busy, "R10 sequence not started",
            32'(cs_rises - rises0), 1);
        chk(sum_done_cnt == sums0, "R10 no sum done", 32'(sum_done_cnt - sums0), 0);

        // R9: matching then mismatching contents
        run_sum(1'b1);
        mem[10] = mem[10] ^ 16'h0100;
        run_sum(1'b0);
        do_read(6'd10);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule